// File: doc/BRIEF.md
# Microprogram Sequencer

This block steps through a read-only control store one microinstruction per clock and turns each word into individual micro-operation command lines for a datapath that is not part of the block. A microinstruction has an operation part and a sequence part. The operation part has four fields: bus source, bus destination, ALU command and memory command. Each field is decoded on its own, so at most one command per field is active in a cycle. The sequence part has a 2-bit condition select and a next-address field.

The store holds a shared fetch routine at address 0, a shared indirect-address routine at 24 and a shared interrupt-entry routine at 28. It also holds one execute routine for each of the four machine opcodes. An opcode dispatch finds the execute routine through a mapping of the opcode. The last word of every execute routine and of the interrupt routine sends control back to fetch. The microaddress register supplies the address of each store read. The microinstruction register always holds the word at that address.

Top module: `useq_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the microaddress is 0. The outputs then show word 0's commands: source PC and destination MAR.
- R2: One microinstruction executes per clock. The fetch routine runs at addresses 0, 1 and 2. Word 0 drives PC to MAR. Word 1 issues a memory read and a PC increment. Word 2 drives MDR to IR.
- R3: Condition code 0 jumps to the next-address field. Every execute routine ends with such a jump to address 0. The interrupt routine also ends with a jump to address 0.
- R4: Condition code 1 dispatches to address 8 + 4*opcode. The execute routines are: opcode 0 load (8–10), opcode 1 store (12–14), opcode 2 add (16–19) and opcode 3 jump (20).
- R5: Condition code 2 at word 2 tests the indirect flag. When the flag is set, control branches to 24. When it is clear, control falls through to 3, which dispatches. The indirect routine runs 24 (IR to MAR), 25 (read) and 26 (MDR to IR, then dispatch).
- R6: Condition code 3 at word 0 tests interrupt-pending. When it is set, control branches to 28. When it is clear, control falls through to 1. The interrupt routine runs 28 (SP decrement), 29 (SP to MAR), 30 (PC to MDR, write) and 31 (vector to PC).
- R7: In each field, code 0 asserts no line and code k asserts only line k-1. Source codes are 1 PC, 2 MDR, 3 IR, 4 ACC, 5 Z, 6 SP, 7 vector. Destination codes are 1 MAR, 2 IR, 3 PC, 4 ACC, 5 MDR, 6 Z. ALU codes are 1 add, 2 PC increment, 3 SP decrement. Memory codes are 1 read, 2 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | asynchronous reset, active high |
| opcode_i | input | OPC_W (2) | machine opcode used at dispatch |
| indirect_i | input | 1 | indirect-addressing flag |
| irq_pend_i | input | 1 | interrupt pending flag |
| upc_o | output | UA_W (5) | current microaddress |
| src_en_o | output | 7 | bus source enables |
| dst_ld_o | output | 7 | bus destination loads |
| alu_cmd_o | output | 7 | ALU commands |
| mem_cmd_o | output | 3 | memory commands (bit0 read, bit1 write) |

## Verification
The bench covers every opcode, and it runs one opcode both with and without the indirect flag. It follows an interrupt that is taken at the head of fetch, then the clean return to fetch. A wrong dispatch mapping would land one routine off and show the wrong commands. A reversed branch test would skip the indirect or interrupt routines, or run them when they are not wanted. A routine whose final word does not return to 0 would run into the empty words. A decoder that is off by one line would assert the wrong enable on every step.

// File: rtl/useq_pkg.sv
package useq_pkg;
   localparam int SRC_W  = 3;
   localparam int DST_W  = 3;
   localparam int ALU_W  = 3;
   localparam int MEM_W  = 2;
   localparam int COND_W = 2;
   localparam int NXT_W  = 5;
   localparam int WORD_W = SRC_W + DST_W + ALU_W + MEM_W + COND_W + NXT_W;

   typedef enum logic [COND_W-1:0] {
      SQ_JUMP = 2'd0,
      SQ_DISP = 2'd1,
      SQ_IND  = 2'd2,
      SQ_IRQ  = 2'd3
   } seq_sel_e;

   typedef struct packed {
      logic [SRC_W-1:0] src;
      logic [DST_W-1:0] dst;
      logic [ALU_W-1:0] alu;
      logic [MEM_W-1:0] mem;
      seq_sel_e         cond;
      logic [NXT_W-1:0] nxt;
   } uword_t;

   function automatic uword_t mk(input int s, input int d, input int a,
                                 input int m, input seq_sel_e c, input int n);
      uword_t w;
      w.src  = SRC_W'(s);
      w.dst  = DST_W'(d);
      w.alu  = ALU_W'(a);
      w.mem  = MEM_W'(m);
      w.cond = c;
      w.nxt  = NXT_W'(n);
      return w;
   endfunction

   function automatic uword_t cs_word(input int adr);
      case (adr)
         0:  return mk(1, 1, 0, 0, SQ_IRQ, 28);
         1:  return mk(0, 0, 2, 1, SQ_JUMP, 2);
         2:  return mk(2, 2, 0, 0, SQ_IND, 24);
         3:  return mk(0, 0, 0, 0, SQ_DISP, 0);
         8:  return mk(3, 1, 0, 0, SQ_JUMP, 9);
         9:  return mk(0, 0, 0, 1, SQ_JUMP, 10);
         10: return mk(2, 4, 0, 0, SQ_JUMP, 0);
         12: return mk(3, 1, 0, 0, SQ_JUMP, 13);
         13: return mk(4, 5, 0, 0, SQ_JUMP, 14);
         14: return mk(0, 0, 0, 2, SQ_JUMP, 0);
         16: return mk(3, 1, 0, 0, SQ_JUMP, 17);
         17: return mk(0, 0, 0, 1, SQ_JUMP, 18);
         18: return mk(2, 6, 1, 0, SQ_JUMP, 19);
         19: return mk(5, 4, 0, 0, SQ_JUMP, 0);
         20: return mk(3, 3, 0, 0, SQ_JUMP, 0);
         24: return mk(3, 1, 0, 0, SQ_JUMP, 25);
         25: return mk(0, 0, 0, 1, SQ_JUMP, 26);
         26: return mk(2, 2, 0, 0, SQ_DISP, 0);
         28: return mk(0, 0, 3, 0, SQ_JUMP, 29);
         29: return mk(6, 1, 0, 0, SQ_JUMP, 30);
         30: return mk(1, 5, 0, 2, SQ_JUMP, 31);
         31: return mk(7, 3, 0, 0, SQ_JUMP, 0);
         default: return mk(0, 0, 0, 0, SQ_JUMP, 0);
      endcase
   endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
   import useq_pkg::*;
#(
   parameter int UA_W = 5
) (
   input  logic [UA_W-1:0] addr_i,
   output uword_t          word_o
);
   if (UA_W < NXT_W) begin : g_chk
      $error("useq_store: UA_W too small for the routine layout");
   end

   always_comb word_o = cs_word(int'(addr_i));
endmodule

// File: rtl/useq_next.sv
module useq_next
   import useq_pkg::*;
#(
   parameter int UA_W      = 5,
   parameter int OPC_W     = 2,
   parameter int DISP_BASE = 8,
   parameter int SLOT_LG   = 2
) (
   input  logic [UA_W-1:0]  uar_i,
   input  seq_sel_e         cond_i,
   input  logic [NXT_W-1:0] nxt_i,
   input  logic [OPC_W-1:0] opcode_i,
   input  logic             ind_i,
   input  logic             irq_i,
   output logic [UA_W-1:0]  next_o
);
   localparam int SPAN = DISP_BASE + ((1 << OPC_W) << SLOT_LG);

   if (SPAN > (1 << UA_W)) begin : g_chk
      $error("useq_next: dispatch table exceeds the control store");
   end

   logic [UA_W-1:0] disp_a, jump_a, seq_a;

   always_comb begin
      disp_a = UA_W'(DISP_BASE) + (UA_W'(opcode_i) << SLOT_LG);
      jump_a = UA_W'(nxt_i);
      seq_a  = uar_i + UA_W'(1);
      unique case (cond_i)
         SQ_JUMP: next_o = jump_a;
         SQ_DISP: next_o = disp_a;
         SQ_IND:  next_o = ind_i ? jump_a : seq_a;
         SQ_IRQ:  next_o = irq_i ? jump_a : seq_a;
         default: next_o = jump_a;
      endcase
   end
endmodule

// File: rtl/useq_fdec.sv
module useq_fdec #(
   parameter int W   = 3,
   parameter bit REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [W-1:0]        code_i,
   output logic [(1<<W)-2:0]   line_o
);
   localparam int N = (1 << W) - 1;

   if (W < 1) begin : g_chk
      $error("useq_fdec: field width must be at least one bit");
   end

   logic [N-1:0] dec;

   for (genvar k = 0; k < N; k++) begin : g_line
      assign dec[k] = (code_i == W'(k + 1));
   end

   if (REG) begin : g_reg
      always_ff @(posedge clk or posedge rst) begin
         if (rst) line_o <= '0;
         else     line_o <= dec;
      end
   end else begin : g_comb
      assign line_o = dec;
   end

   AST_FIELD_EXCL: assert property (@(posedge clk) disable iff (rst)
      $onehot0(line_o)) else $error("field drives more than one command"); // R7
endmodule

// File: rtl/useq_top.sv
module useq_top
   import useq_pkg::*;
#(
   parameter int UA_W      = 5,
   parameter int OPC_W     = 2,
   parameter int DISP_BASE = 8,
   parameter int SLOT_LG   = 2,
   parameter bit DEC_REG   = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [OPC_W-1:0]            opcode_i,
   input  logic                        indirect_i,
   input  logic                        irq_pend_i,
   output logic [UA_W-1:0]             upc_o,
   output logic [(1<<SRC_W)-2:0]       src_en_o,
   output logic [(1<<DST_W)-2:0]       dst_ld_o,
   output logic [(1<<ALU_W)-2:0]       alu_cmd_o,
   output logic [(1<<MEM_W)-2:0]       mem_cmd_o
);
   if (UA_W < NXT_W) begin : g_chk
      $error("useq_top: microaddress narrower than next-address field");
   end

   logic [UA_W-1:0] uar, nxt_a;
   uword_t          uir, rom_w;

   useq_next #(.UA_W(UA_W), .OPC_W(OPC_W), .DISP_BASE(DISP_BASE), .SLOT_LG(SLOT_LG)) u_next (
      .uar_i(uar), .cond_i(uir.cond), .nxt_i(uir.nxt), .opcode_i(opcode_i),
      .ind_i(indirect_i), .irq_i(irq_pend_i), .next_o(nxt_a));

   useq_store #(.UA_W(UA_W)) u_store (.addr_i(nxt_a), .word_o(rom_w));

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         uar <= '0;
         uir <= cs_word(0);
      end else begin
         uar <= nxt_a;
         uir <= rom_w;
      end
   end

   assign upc_o = uar;

   useq_fdec #(.W(SRC_W), .REG(DEC_REG)) u_src (.clk(clk), .rst(rst), .code_i(uir.src), .line_o(src_en_o));
   useq_fdec #(.W(DST_W), .REG(DEC_REG)) u_dst (.clk(clk), .rst(rst), .code_i(uir.dst), .line_o(dst_ld_o));
   useq_fdec #(.W(ALU_W), .REG(DEC_REG)) u_alu (.clk(clk), .rst(rst), .code_i(uir.alu), .line_o(alu_cmd_o));
   useq_fdec #(.W(MEM_W), .REG(DEC_REG)) u_mem (.clk(clk), .rst(rst), .code_i(uir.mem), .line_o(mem_cmd_o));

   AST_RESET_FETCH: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (uar == '0)) else $error("not at fetch entry after reset"); // R1
   AST_WORD_MATCH: assert property (@(posedge clk) disable iff (rst)
      uir == cs_word(int'(uar))) else $error("microinstruction register out of step"); // R2
   AST_JUMP_FIELD: assert property (@(posedge clk) disable iff (rst)
      (uir.cond == SQ_JUMP) |=> (uar == UA_W'($past(uir.nxt)))) else $error("jump target wrong"); // R3
   AST_DISPATCH: assert property (@(posedge clk) disable iff (rst)
      (uir.cond == SQ_DISP) |=> (uar == UA_W'(DISP_BASE) + (UA_W'($past(opcode_i)) << SLOT_LG)))
      else $error("dispatch target wrong"); // R4
   AST_IND_BRANCH: assert property (@(posedge clk) disable iff (rst)
      (uir.cond == SQ_IND) |=> (uar == ($past(indirect_i) ? UA_W'($past(uir.nxt)) : $past(uar) + UA_W'(1))))
      else $error("indirect branch wrong"); // R5
   AST_IRQ_BRANCH: assert property (@(posedge clk) disable iff (rst)
      (uir.cond == SQ_IRQ) |=> (uar == ($past(irq_pend_i) ? UA_W'($past(uir.nxt)) : $past(uar) + UA_W'(1))))
      else $error("interrupt branch wrong"); // R6
endmodule

// File: tb/tb_useq_top.sv
`timescale 1ns/1ps
module tb_useq_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [1:0] opcode = '0;
   logic ind = 1'b0, irq = 1'b0;
   logic [4:0] upc;
   logic [6:0] src_en, dst_ld, alu_cmd;
   logic [2:0] mem_cmd;
   int tests = 0, fails = 0;
   bit done = 1'b0;

   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   useq_top dut (.clk(clk), .rst(rst), .opcode_i(opcode), .indirect_i(ind), .irq_pend_i(irq),
                 .upc_o(upc), .src_en_o(src_en), .dst_ld_o(dst_ld), .alu_cmd_o(alu_cmd), .mem_cmd_o(mem_cmd));

   function automatic logic [6:0] ln(input int c);
      return (c == 0) ? 7'd0 : 7'(1 << (c - 1));
   endfunction

   task automatic push(input int a, input int s, input int d, input int al, input int m, input string t);
      exp_q.push_back({5'(a), 3'(s), 3'(d), 3'(al), 2'(m)});
      tag_q.push_back(t);
   endtask

   task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp, input string what);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
      end
   endtask

   // monitor: compares the design state against the scoreboard on every falling edge
   always @(negedge clk) begin
      if (!rst && exp_q.size() > 0) begin
         logic [15:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, 32'(upc), 32'(e[15:11]), "upc");
         check("R7", 32'(src_en), 32'(ln(int'(e[10:8]))), "src");
         check("R7", 32'(dst_ld), 32'(ln(int'(e[7:5]))), "dst");
         check("R7", 32'(alu_cmd), 32'(ln(int'(e[4:2]))), "alu");
         check("R7", 32'(mem_cmd), 32'(3'(ln(int'(e[1:0])))), "mem");
      end
   end

   task automatic fetch_head(input string t);
      push(0, 1, 1, 0, 0, "R1");
      push(1, 0, 0, 2, 1, "R2");
      push(2, 2, 2, 0, 0, t);
   endtask

   task automatic ind_path;
      push(24, 3, 1, 0, 0, "R5");
      push(25, 0, 0, 0, 1, "R5");
      push(26, 2, 2, 0, 0, "R5");
   endtask

   task automatic drain;
      wait (exp_q.size() == 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", 32'(upc), 0, "upc in reset");
      check("R1", 32'(src_en), 32'(ln(1)), "src in reset");
      check("R1", 32'(dst_ld), 32'(ln(1)), "dst in reset");
      @(posedge clk);
      #1 rst = 1'b0;
      // load, direct
      opcode = 2'd0; ind = 1'b0; irq = 1'b0;
      fetch_head("R2");
      push(3, 0, 0, 0, 0, "R5");
      push(8, 3, 1, 0, 0, "R4");
      push(9, 0, 0, 0, 1, "R4");
      push(10, 2, 4, 0, 0, "R3");
      drain();
      // store, indirect
      opcode = 2'd1; ind = 1'b1;
      fetch_head("R5");
      ind_path();
      push(12, 3, 1, 0, 0, "R4");
      push(13, 4, 5, 0, 0, "R4");
      push(14, 0, 0, 0, 2, "R3");
      drain();
      // add, direct
      opcode = 2'd2; ind = 1'b0;
      fetch_head("R2");
      push(3, 0, 0, 0, 0, "R5");
      push(16, 3, 1, 0, 0, "R4");
      push(17, 0, 0, 0, 1, "R4");
      push(18, 2, 6, 1, 0, "R4");
      push(19, 5, 4, 0, 0, "R3");
      drain();
      // jump, direct
      opcode = 2'd3;
      fetch_head("R2");
      push(3, 0, 0, 0, 0, "R5");
      push(20, 3, 3, 0, 0, "R3");
      drain();
      // interrupt pending at fetch entry
      irq = 1'b1;
      push(0, 1, 1, 0, 0, "R6");
      push(28, 0, 0, 3, 0, "R6");
      push(29, 6, 1, 0, 0, "R6");
      push(30, 1, 5, 0, 2, "R6");
      push(31, 7, 3, 0, 0, "R6");
      drain();
      // after the interrupt: jump, indirect
      irq = 1'b0; ind = 1'b1; opcode = 2'd3;
      fetch_head("R3");
      ind_path();
      push(20, 3, 3, 0, 0, "R4");
      drain();
      // back at fetch entry
      push(0, 1, 1, 0, 0, "R3");
      drain();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule